// File: doc/BRIEF.md
# Device Interrupt Pin Routing Table

This block decides which of eight shared interrupt request lines, numbered 0 to 7, each PCI device interrupt pin (INTA, INTB, INTC or INTD) is steered onto. Firmware programs the mapping through a small byte-addressed register window. Each access carries an address, a byte length of 1 to 4 and a 32-bit data word packed little-endian. The block keeps the window in flip-flops and derives its route table from it. A combinational lookup port answers the question "slot S, pin P goes to which shared line?" in the same cycle.

Seven device numbers (25 to 31) own a 16-bit route register each. Device 30 is the exception: its register is read-only zero and its pins are wired to lines 4 to 7 in pin order. Every other slot uses a rotating default that only ever lands on lines 4 to 7. Every write, whatever it touches, produces a one-cycle routing-changed pulse, so that downstream logic can re-sample its routes.

Top module: `irq_pin_router`

## Requirements
- R1: After reset, the route registers of devices 25, 26, 27, 28, 29 and 31 hold 16'h3210, which maps pin i to line i. The control word at byte offset 16 holds 32'h0000_0021. Every other window byte is zero.
- R2: The route register of device d sits at byte offset 2*(d-25), low byte first. The field for pin i (0 = INTA) is bits 4i+3..4i. Only the low 3 bits of a field give the line index (0..7), and bit 3 is ignored by the lookup.
- R3: Device 30's register (bytes 10 and 11) always reads zero and ignores writes. Lookup of slot 30 pin p returns 4+p.
- R4: Lookup of any slot outside 25..31 with pin p returns ((slot + p) mod 4) + 4, which is always 4 or more.
- R5: Only the low log2(WIN_BYTES) address bits are used, so 0x46 and 0x06 reach the same byte with the default 32-byte window.
- R6: An access at masked offset a with a+len beyond the window is cut to WIN_BYTES-a bytes. It never wraps to byte 0, and the bytes that were cut read as zero.
- R7: A read returns the covered bytes little-endian and zero-extended to 32 bits. rdata is zero when the read strobe is low.
- R8: route_chg is high in exactly the cycle after each write cycle and low otherwise.
- R9: The lookup port is combinational and reflects a write from the clock edge that stores it. A partial write changes only the bytes it covers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address, masked to the window |
| len | input | 3 | Access length in bytes, 1 to 4 |
| wdata | input | 32 | Write data, little-endian |
| rdata | output | 32 | Read data, combinational |
| route_chg | output | 1 | One-cycle pulse after every write |
| lk_slot | input | 5 | Lookup device slot |
| lk_pin | input | 2 | Lookup pin, 0 = INTA |
| lk_pirq | output | 3 | Shared line index for the lookup |

## Verification
The assertions hold on every cycle for the fixed wiring of device 30, the range of the rotating default for unprogrammed slots, the pulse shape of route_chg, the zero read value when the strobe is idle, and the reset-time identity map of a programmable device. Address masking, length clipping without wrap-around, partial byte updates and the mapping written into each programmable register depend on the access sequence. Only the bench's directed writes and read-backs can show those.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;

    localparam int WIN_BYTES_DEF = 32;
    localparam int FIRST_DEV     = 25;
    localparam int LAST_DEV      = 31;
    localparam int FIXED_DEV     = 30;
    localparam int FIELD_W       = 4;
    localparam int CTRL_OFF      = 16;
    localparam logic [15:0] ROUTE_DEFAULT = 16'h3210;
    localparam logic [31:0] CTRL_DEFAULT  = 32'h0000_0021;

    typedef struct packed {
        logic [4:0] slot;
        logic [1:0] pin;
    } rt_query_t;

    function automatic bit is_fixed_byte(int b);
        return (b == 2 * (FIXED_DEV - FIRST_DEV)) || (b == 2 * (FIXED_DEV - FIRST_DEV) + 1);
    endfunction

    function automatic logic [7:0] default_byte(int b);
        logic [7:0] v;
        v = 8'h00;
        if (b < 2 * (LAST_DEV - FIRST_DEV + 1) && !is_fixed_byte(b))
            v = ROUTE_DEFAULT[8 * (b % 2) +: 8];
        else if (b >= CTRL_OFF && b < CTRL_OFF + 4)
            v = CTRL_DEFAULT[8 * (b - CTRL_OFF) +: 8];
        return v;
    endfunction

endpackage

// File: rtl/irq_rt_window.sv
module irq_rt_window
    import irq_rt_pkg::*;
#(
    parameter int WIN_BYTES = WIN_BYTES_DEF,
    parameter int ADDR_W    = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [2:0]             len,
    input  logic [31:0]            wdata,
    output logic [31:0]            rdata,
    output logic [WIN_BYTES*8-1:0] win_q
);
    localparam int AW = $clog2(WIN_BYTES);

    logic [AW-1:0] base;
    logic [AW:0]   room;
    logic [AW:0]   len_eff;
    logic [AW:0]   len_ext;
    logic          unused_hi;
    logic [7:0]    wb [4];

    assign base      = addr[AW-1:0];
    assign unused_hi = ^addr[ADDR_W-1:AW];
    assign room      = (AW+1)'(WIN_BYTES) - {1'b0, base};
    assign len_ext   = (AW+1)'(len);
    assign len_eff   = (len_ext > room) ? room : len_ext;

    always_comb begin
        for (int i = 0; i < 4; i++) wb[i] = wdata[8*i +: 8];
    end

    for (genvar b = 0; b < WIN_BYTES; b++) begin : g_byte
        logic [AW:0] off;
        logic        hit;
        assign off = (AW+1)'(b) - {1'b0, base};
        assign hit = ((AW+1)'(b) >= {1'b0, base}) && (off < len_eff);
        if (is_fixed_byte(b)) begin : g_ro
            assign win_q[8*b +: 8] = 8'h00;
        end else begin : g_rw
            logic [7:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= default_byte(b);
                else if (wr_en && hit)
                    q <= wb[off[1:0]];
            end
            assign win_q[8*b +: 8] = q;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < 4; i++) begin
            logic [AW:0] idx;
            idx = {1'b0, base} + (AW+1)'(i);
            if (rd_en && ((AW+1)'(i) < len_eff))
                rdata[8*i +: 8] = win_q[8*idx[AW-1:0] +: 8];
        end
    end
endmodule

// File: rtl/irq_rt_lookup.sv
module irq_rt_lookup
    import irq_rt_pkg::*;
#(
    parameter int WIN_BYTES = WIN_BYTES_DEF
) (
    input  logic [WIN_BYTES*8-1:0] win_q,
    input  rt_query_t              q,
    output logic [2:0]             pirq
);
    logic [15:0] route;
    logic [2:0]  dev_idx;
    logic [1:0]  rot;
    logic        programmable;

    assign dev_idx      = 3'(q.slot - 5'(FIRST_DEV));
    assign programmable = (q.slot >= 5'(FIRST_DEV)) && (q.slot != 5'(FIXED_DEV));
    assign rot          = q.slot[1:0] + q.pin;

    always_comb begin
        route = win_q[16*dev_idx +: 16];
        if (q.slot == 5'(FIXED_DEV))
            pirq = {1'b1, q.pin};
        else if (programmable)
            pirq = route[FIELD_W*q.pin +: 3];
        else
            pirq = {1'b1, rot};
    end
endmodule

// File: rtl/irq_pin_router.sv
module irq_pin_router
    import irq_rt_pkg::*;
#(
    parameter int WIN_BYTES = WIN_BYTES_DEF,
    parameter int ADDR_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        len,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              route_chg,
    input  logic [4:0]        lk_slot,
    input  logic [1:0]        lk_pin,
    output logic [2:0]        lk_pirq
);
    logic [WIN_BYTES*8-1:0] win_q;
    rt_query_t              query;

    assign query = '{slot: lk_slot, pin: lk_pin};

    irq_rt_window #(.WIN_BYTES(WIN_BYTES), .ADDR_W(ADDR_W)) u_win (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .len(len), .wdata(wdata), .rdata(rdata), .win_q(win_q)
    );

    irq_rt_lookup #(.WIN_BYTES(WIN_BYTES)) u_lk (
        .win_q(win_q), .q(query), .pirq(lk_pirq)
    );

    always_ff @(posedge clk) begin
        if (rst) route_chg <= 1'b0;
        else     route_chg <= wr_en;
    end
endmodule

// File: rtl/irq_pin_router_chk.sv
module irq_pin_router_chk #(
    parameter int WIN_BYTES = 32
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   wr_en,
    input logic                   rd_en,
    input logic [31:0]            rdata,
    input logic                   route_chg,
    input logic [4:0]             lk_slot,
    input logic [1:0]             lk_pin,
    input logic [2:0]             lk_pirq,
    input logic [WIN_BYTES*8-1:0] win_q
);
    p_fixed_slot_r3: assert property (@(posedge clk) disable iff (rst)
        lk_slot == 5'd30 |-> lk_pirq == {1'b1, lk_pin});

    p_fixed_bytes_r3: assert property (@(posedge clk) disable iff (rst)
        win_q[95:80] == 16'h0000);

    p_default_range_r4: assert property (@(posedge clk) disable iff (rst)
        lk_slot < 5'd25 |-> lk_pirq[2]);

    p_chg_after_wr_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> route_chg);

    p_chg_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> !route_chg);

    p_idle_read_r7: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> rdata == 32'h0);

    p_reset_ident_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && lk_slot == 5'd25) |-> lk_pirq == {1'b0, lk_pin});
endmodule

bind irq_pin_router irq_pin_router_chk #(.WIN_BYTES(WIN_BYTES)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
    .route_chg(route_chg), .lk_slot(lk_slot), .lk_pin(lk_pin),
    .lk_pirq(lk_pirq), .win_q(win_q)
);

// File: tb/irq_pin_router_bench.sv
module irq_pin_router_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [15:0] addr = '0;
    logic [2:0]  len = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        route_chg;
    logic [4:0]  lk_slot = '0;
    logic [1:0]  lk_pin = '0;
    logic [2:0]  lk_pirq;
    int errors = 0, checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_pin_router u_irq_pin_router (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .len(len), .wdata(wdata), .rdata(rdata), .route_chg(route_chg),
        .lk_slot(lk_slot), .lk_pin(lk_pin), .lk_pirq(lk_pirq)
    );

    // {slot, pin, expected line} after reset
    localparam logic [9:0] VEC [12] = '{
        {5'd0,  2'd0, 3'd4}, {5'd1,  2'd2, 3'd7}, {5'd3,  2'd3, 3'd6},
        {5'd24, 2'd1, 3'd5}, {5'd14, 2'd3, 3'd5}, {5'd2,  2'd2, 3'd4},
        {5'd25, 2'd0, 3'd0}, {5'd29, 2'd2, 3'd2}, {5'd27, 2'd1, 3'd1},
        {5'd31, 2'd3, 3'd3}, {5'd30, 2'd0, 3'd4}, {5'd30, 2'd3, 3'd7}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [2:0] n, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; len = n; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        check("R8 pulse after write", 32'(route_chg), 32'd1);
    endtask

    task automatic rd(logic [15:0] a, logic [2:0] n, logic [31:0] exp, string req);
        @(negedge clk);
        rd_en = 1'b1; addr = a; len = n;
        #1 check(req, rdata, exp);
        rd_en = 1'b0;
    endtask

    task automatic look(logic [4:0] s, logic [1:0] p, logic [2:0] exp, string req);
        lk_slot = s; lk_pin = p;
        #1 check(req, 32'(lk_pirq), 32'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8 idle after reset", 32'(route_chg), 32'd0);
        for (int i = 0; i < 12; i++)
            look(VEC[i][9:5], VEC[i][4:3], VEC[i][2:0], "R1/R3/R4 table lookup");
        rd(16'd0,  3'd4, 32'h3210_3210, "R1 dev25/26 defaults");
        rd(16'd8,  3'd4, 32'h0000_3210, "R3 dev30 bytes read zero");
        rd(16'd12, 3'd2, 32'h0000_3210, "R1 dev31 default");
        rd(16'd16, 3'd4, 32'h0000_0021, "R1 control default");
        rd(16'd20, 3'd4, 32'h0, "R1 other bytes zero");
        rd(16'd0,  3'd1, 32'h10, "R7 single byte zero-extended");
        @(negedge clk);
        #1 check("R7 idle read zero", rdata, 32'h0);
        check("R8 no pulse when idle", 32'(route_chg), 32'd0);
        // R2/R9: program device 27 (offset 4)
        wr(16'd4, 3'd2, 32'h0000_7654);
        look(5'd27, 2'd0, 3'd4, "R9 dev27 pin A");
        look(5'd27, 2'd3, 3'd7, "R2 dev27 pin D");
        look(5'd26, 2'd3, 3'd3, "R9 neighbour untouched");
        // R3: device 30 ignores writes
        wr(16'd10, 3'd2, 32'h0000_FFFF);
        rd(16'd10, 3'd2, 32'h0, "R3 dev30 write ignored");
        look(5'd30, 2'd1, 3'd5, "R3 dev30 fixed");
        // R5: masked address 0x46 -> byte 6 (device 28 low byte)
        wr(16'h0046, 3'd1, 32'h0000_0005);
        look(5'd28, 2'd0, 3'd5, "R5 masked write pin A");
        look(5'd28, 2'd1, 3'd0, "R5 masked write pin B");
        look(5'd28, 2'd2, 3'd2, "R9 partial write keeps high byte");
        rd(16'h0026, 3'd2, 32'h0000_3205, "R5 masked read");
        // R2: bit 3 of each field ignored
        wr(16'd12, 3'd2, 32'h0000_F9A8);
        look(5'd31, 2'd0, 3'd0, "R2 field 8 -> 0");
        look(5'd31, 2'd1, 3'd2, "R2 field A -> 2");
        look(5'd31, 2'd2, 3'd1, "R2 field 9 -> 1");
        look(5'd31, 2'd3, 3'd7, "R2 field F -> 7");
        // R6: clipping at end of window
        wr(16'd30, 3'd4, 32'hAABB_CCDD);
        rd(16'd30, 3'd4, 32'h0000_CCDD, "R6 clipped read");
        rd(16'd0,  3'd2, 32'h0000_3210, "R6 no wrap to byte 0");
        // R1: reset restores defaults
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        look(5'd27, 2'd3, 3'd3, "R1 reset restores dev27");
        look(5'd31, 2'd1, 3'd1, "R1 reset restores dev31");
        rd(16'd30, 3'd2, 32'h0, "R1 reset clears tail bytes");
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule